// File: doc/BRIEF.md
# Idle-Timeout Power-Save Gate

This block sits beside the read path of a memory array. It watches the address bus and the three active-low strobes: chip select, write strobe and output enable. When none of them has moved for a set number of clock cycles while the chip is selected and no write is under way, it raises a power-save flag. The surrounding array logic can use that flag to stop its sense circuits.

While the flag is high, the data output does not follow the array. It keeps the word that was on the array data input when power save began, so a reader still sees the last word it fetched. Any movement on a watched input ends power save. On the clock edge that sees that movement the output goes back to tracking the array, and a fresh idle count begins.

After reset the block is disarmed. It stays out of power save until chip select has changed level at least once. Reset is synchronous and active high. The timeout is counted in clock cycles and must be at least 2. For example, 20 cycles at a 10 ns clock gives roughly a 200 ns idle window.

Top module: `idle_power_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `save_o` is 0 and `dout` equals `arr_data`.
- R2: After reset, `save_o` stays 0 however long the inputs are quiet, until `ce_n` has changed level at least once.
- R3: Once armed, with `ce_n` = 0 and `we_n` = 1, `save_o` rises on the TIMEOUT-th consecutive rising clock edge after the edge that last saw an input change, and not earlier.
- R4: A change on `addr`, `ce_n`, `we_n` or `oe_n` restarts the idle count. This includes a change that arrives on the edge where the count would otherwise reach TIMEOUT.
- R5: When `save_o` is 1 and a watched input changes, `save_o` is 0 after the next rising edge.
- R6: While `save_o` stays 1, `dout` holds the `arr_data` value sampled on the edge where `save_o` rose, whatever `arr_data` does.
- R7: While `save_o` is 0, `dout` equals `arr_data` in the same cycle.
- R8: `save_o` never rises while `ce_n` = 1 (deselected) or `we_n` = 0 (write).
- R9: A reset pulse issued during power save clears `save_o` and disarms the block, so R2 applies again afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Address bus being watched |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | DW | Word read from the array |
| save_o | output | 1 | Power-save flag |
| dout | output | DW | Data output, held while power save is active |

## Verification
Two events can land on the same edge: the idle count reaching the timeout, and a fresh address change that restarts it. The bench makes the address change after exactly TIMEOUT-1 quiet edges, so the change and the would-be entry fall on one clock edge. It then requires that the flag stays low and that a complete new window of TIMEOUT quiet edges is needed before entry. A second overlap is covered as well: the exit edge is also the first edge on which a new array word must appear on `dout`.

// File: rtl/idle_power_gate.sv
module idle_power_gate #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int TIMEOUT = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_data,
  output logic          save_o,
  output logic [DW-1:0] dout
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [AW-1:0] addr_q;
  logic          ce_q, we_q, oe_q;
  logic          armed, save_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] held;
  logic          chg, elig, reach;

  assign chg   = (addr != addr_q) | (ce_n != ce_q) | (we_n != we_q) | (oe_n != oe_q);
  assign elig  = armed & ~ce_n & we_n;
  assign reach = (cnt >= LIMIT - 1'b1);

  always_ff @(posedge clk) begin
    addr_q <= addr;
    ce_q   <= ce_n;
    we_q   <= we_n;
    oe_q   <= oe_n;
    if (rst) begin
      armed  <= 1'b0;
      cnt    <= '0;
      save_q <= 1'b0;
      held   <= '0;
    end else begin
      if (ce_n != ce_q) armed <= 1'b1;
      if (chg || !elig)      cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
      save_q <= !chg && elig && reach;
      if (!save_q) held <= arr_data;
    end
  end

  assign save_o = save_q;
  assign dout   = save_q ? held : arr_data;

  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !save_o);

  // R3
  entry_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(save_o) |-> ($past(cnt) == LIMIT - 1'b1));

  // R4 R5
  exit_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (save_o && chg) |=> (!save_o && cnt == '0));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (save_o && $past(save_o)) |-> $stable(dout));

  // R8
  selected_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(save_o) |-> $past(!ce_n && we_n));
endmodule

// File: tb/test_idle_power_gate.sv
module test_idle_power_gate;
  localparam int AW = 16, DW = 16, T = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] arr_data = 16'h1111;
  logic save_o;
  logic [DW-1:0] dout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idle_power_gate #(.AW(AW), .DW(DW), .TIMEOUT(T)) i_idle_power_gate (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .arr_data(arr_data), .save_o(save_o), .dout(dout));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic arm();
    ce_n = 1'b1;
    tick();
    ce_n = 1'b0;
    tick();
  endtask

  task automatic test_reset();
    ce_n = 1'b0; arr_data = 16'h1111;
    do_reset();
    chk("R1 save after reset", save_o, 1'b0);
    arr_data = 16'h2222; #1;
    chk("R1 dout follows", dout, 16'h2222);
  endtask

  task automatic test_unarmed();
    tick(3 * T);
    chk("R2 no save before ce toggle", save_o, 1'b0);
  endtask

  task automatic test_entry();
    arm();
    tick(T - 1);
    chk("R3 not before timeout", save_o, 1'b0);
    arr_data = 16'hA5A5;
    tick();
    chk("R3 save at timeout", save_o, 1'b1);
  endtask

  task automatic test_hold_and_exit();
    arr_data = 16'h5A5A; #1;
    chk("R6 dout held", dout, 16'hA5A5);
    tick(3);
    chk("R6 dout still held", dout, 16'hA5A5);
    addr = addr + 1'b1;
    arr_data = 16'h7777; #1;
    chk("R6 held in exit cycle", dout, 16'hA5A5);
    tick();
    chk("R5 save low after change", save_o, 1'b0);
    chk("R5 dout new data", dout, 16'h7777);
  endtask

  task automatic test_pass();
    arr_data = 16'h0F0F; #1;
    chk("R7 dout tracks array", dout, 16'h0F0F);
  endtask

  task automatic test_restart();
    tick(T - 1);
    addr = addr + 1'b1;
    tick();
    chk("R4 addr change on timeout edge", save_o, 1'b0);
    tick(T - 2);
    oe_n = ~oe_n;
    tick();
    chk("R4 oe change restarts", save_o, 1'b0);
    tick(T - 1);
    chk("R4 full window needed", save_o, 1'b0);
    tick();
    chk("R4 entry after new window", save_o, 1'b1);
  endtask

  task automatic test_blocked();
    we_n = 1'b0;
    tick(3 * T);
    chk("R8 no save during write", save_o, 1'b0);
    we_n = 1'b1;
    ce_n = 1'b1;
    tick(3 * T);
    chk("R8 no save when deselected", save_o, 1'b0);
    ce_n = 1'b0;
    tick(T + 1);
    chk("R8 save after reselect", save_o, 1'b1);
  endtask

  task automatic test_reset_disarm();
    do_reset();
    chk("R9 reset clears save", save_o, 1'b0);
    tick(3 * T);
    chk("R9 disarmed after reset", save_o, 1'b0);
    arm();
    tick(T);
    chk("R9 rearmed by ce toggle", save_o, 1'b1);
  endtask

  initial begin
    test_reset();
    test_unarmed();
    test_entry();
    test_hold_and_exit();
    test_pass();
    test_restart();
    test_blocked();
    test_reset_disarm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule